// File: doc/BRIEF.md
# Configuration Mode and Clock Select Control Register

This block holds two control bits for a link endpoint. The first bit is a configuration-mode switch. While it is set, every incoming transaction packet is steered to the configuration space, and the configuration controller is told that configuration mode is running. While it is clear, packets go to the user fabric. The bit can only be set while an external configuration-enable flag is high, and it is forced low whenever that flag is low.

The second bit is a clock-select request. A 1 asks for the internal transceiver clock and a 0 asks for the fabric clock. A requested change reaches the clock-select output only while the user-mode and core-ready flags are both high. Before the change the link must have been quiet for a full window, and after it the block holds activity off for a second window. Both windows last a set number of microseconds, counted in system clock cycles. Software writes both bits through a small register port. On the read side it sees the two bits and a busy flag that stays high while a switchover is in progress.

Top module: `cfgm_ctrl`

## Requirements
- R1: A write with `cfg_enable` high loads `wr_data[0]` into the mode bit. From the next cycle `route_to_cfg` equals the written value: 1 sends packets to the configuration space, 0 sends them to the fabric.
- R2: While `cfg_enable` is low, the mode bit is 0 from the next cycle on. A write of 1 made while the flag is low is ignored.
- R3: A write loads `wr_data[1]` into the clock-select request. Readback places the request at `rd_data[1]` and the mode bit at `rd_data[0]`.
- R4: `clk_sel` changes only in a cycle that follows one in which `user_mode` and `core_ready` were both high. A request waits as long as either flag is low.
- R5: A request that differs from `clk_sel` is applied only after QUIET_CYC = QUIET_US*CLK_MHZ consecutive cycles with `link_active` low, counted from the cycle after the request is seen.
- R6: Any cycle with `link_active` high during the pre-change window restarts the idle count from zero.
- R7: `hold_off` is high for exactly QUIET_CYC cycles, starting in the cycle in which `clk_sel` changes.
- R8: `rd_data[2]` (busy) is 1 while a switchover is waiting for its idle window or is in hold-off, and 0 otherwise.
- R9: After reset the mode bit, the request, `clk_sel`, `hold_off` and all of `rd_data` are 0.
- R10: If the request is written back to the value of `clk_sel`, or a gating flag drops, before the idle window completes, the pending switch is dropped and busy returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | DATA_W | Write data; bit 0 is the mode bit, bit 1 is the clock-select request |
| rd_data | output | DATA_W | Readback: bit 0 mode, bit 1 request, bit 2 busy, other bits 0 |
| cfg_enable | input | 1 | Permits configuration mode |
| user_mode | input | 1 | Device is in user mode |
| core_ready | input | 1 | Core reports ready |
| link_active | input | 1 | Link carried traffic this cycle |
| route_to_cfg | output | 1 | 1: packets go to the configuration space and the controller sees the mode as active |
| clk_sel | output | 1 | Applied clock select: 1 internal transceiver clock, 0 fabric clock |
| hold_off | output | 1 | Activity must be held off (post-change window) |

## Verification
Two events can meet in one cycle: a register write that changes the clock-select request, and the last cycle of the idle window, which applies the request that was pending before the write. The bench watches its own model for the cycle where the idle count is one short of its limit, and it places a write of the opposite value in exactly that cycle. It then checks that the older request is applied and that the new one starts a fresh switchover. In the same way, a write of 1 to the mode bit is made in the same cycle that `cfg_enable` falls, and the bench checks that the bit stays 0.

// File: rtl/cfgm_pkg.sv
package cfgm_pkg;
  typedef enum logic [1:0] {
    SW_IDLE = 2'd0,
    SW_PRE  = 2'd1,
    SW_POST = 2'd2
  } sw_state_e;
endpackage

// File: rtl/cfgm_mode_bit.sv
module cfgm_mode_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  input  logic cfg_enable,
  output logic mode_q
);
  logic mode_n;

  always_comb begin
    mode_n = mode_q;
    if (wr_en) mode_n = wr_bit;
    if (!cfg_enable) mode_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= mode_n;
  end
endmodule

// File: rtl/cfgm_quiet_timer.sv
module cfgm_quiet_timer #(
  parameter int unsigned LIMIT = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic done
);
  localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);

  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (clr)      cnt_n = '0;
    else if (inc) cnt_n = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign done = (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/cfgm_switch_fsm.sv
module cfgm_switch_fsm
  import cfgm_pkg::*;
#(
  parameter int unsigned QUIET_CYC = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_req,
  input  logic gate_ok,
  input  logic link_active,
  output logic clk_sel,
  output logic hold_off,
  output logic busy
);
  sw_state_e st_q, st_n;
  logic      app_q, app_n;
  logic      t_clr, t_inc, t_done;
  logic      want;

  cfgm_quiet_timer #(.LIMIT(QUIET_CYC)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (t_clr),
    .inc  (t_inc),
    .done (t_done)
  );

  assign want = gate_ok && (sel_req != app_q);

  always_comb begin
    st_n  = st_q;
    app_n = app_q;
    t_clr = 1'b0;
    t_inc = 1'b0;
    case (st_q)
      SW_IDLE: begin
        t_clr = 1'b1;
        if (want) st_n = SW_PRE;
      end
      SW_PRE: begin
        if (!want) begin
          st_n  = SW_IDLE;
          t_clr = 1'b1;
        end else if (link_active) begin
          t_clr = 1'b1;
        end else if (t_done) begin
          app_n = sel_req;
          st_n  = SW_POST;
          t_clr = 1'b1;
        end else begin
          t_inc = 1'b1;
        end
      end
      SW_POST: begin
        if (t_done) begin
          st_n  = SW_IDLE;
          t_clr = 1'b1;
        end else begin
          t_inc = 1'b1;
        end
      end
      default: begin
        st_n  = SW_IDLE;
        t_clr = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SW_IDLE;
      app_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      app_q <= app_n;
    end
  end

  assign clk_sel  = app_q;
  assign hold_off = (st_q == SW_POST);
  assign busy     = (st_q != SW_IDLE);
endmodule

// File: rtl/cfgm_ctrl.sv
module cfgm_ctrl #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CLK_MHZ  = 125,
  parameter int unsigned QUIET_US = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              cfg_enable,
  input  logic              user_mode,
  input  logic              core_ready,
  input  logic              link_active,
  output logic              route_to_cfg,
  output logic              clk_sel,
  output logic              hold_off
);
  localparam int unsigned QUIET_CYC = QUIET_US * CLK_MHZ;
  localparam int unsigned MODE_B = 0;
  localparam int unsigned SEL_B  = 1;
  localparam int unsigned BUSY_B = 2;

  logic mode_q;
  logic sel_q, sel_n;
  logic busy;

  cfgm_mode_bit u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_bit    (wr_data[MODE_B]),
    .cfg_enable(cfg_enable),
    .mode_q    (mode_q)
  );

  always_comb begin
    sel_n = sel_q;
    if (wr_en) sel_n = wr_data[SEL_B];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= sel_n;
  end

  cfgm_switch_fsm #(.QUIET_CYC(QUIET_CYC)) u_sw (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_req    (sel_q),
    .gate_ok    (user_mode && core_ready),
    .link_active(link_active),
    .clk_sel    (clk_sel),
    .hold_off   (hold_off),
    .busy       (busy)
  );

  always_comb begin
    rd_data         = '0;
    rd_data[MODE_B] = mode_q;
    rd_data[SEL_B]  = sel_q;
    rd_data[BUSY_B] = busy;
  end

  assign route_to_cfg = mode_q;
endmodule

// File: rtl/cfgm_ctrl_chk.sv
module cfgm_ctrl_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              cfg_enable,
  input logic              user_mode,
  input logic              core_ready,
  input logic              link_active,
  input logic              route_to_cfg,
  input logic              clk_sel,
  input logic              hold_off
);
  // R1
  mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cfg_enable) |=> (route_to_cfg == $past(wr_data[0])));

  // R2
  mode_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> !route_to_cfg);

  // R4
  sel_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clk_sel) |-> $past(user_mode && core_ready));

  // R5
  sel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clk_sel) |-> $past(!link_active));

  // R7
  holdoff_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clk_sel) |-> hold_off);

  // R8
  busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_off |-> rd_data[2]);
endmodule

bind cfgm_ctrl cfgm_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .rd_data     (rd_data),
  .cfg_enable  (cfg_enable),
  .user_mode   (user_mode),
  .core_ready  (core_ready),
  .link_active (link_active),
  .route_to_cfg(route_to_cfg),
  .clk_sel     (clk_sel),
  .hold_off    (hold_off)
);

// File: tb/cfgm_ctrl_tb.sv
`timescale 1ns/1ps
module cfgm_ctrl_tb;
  localparam int DW = 32;
  localparam int MHZ = 1;
  localparam int QUS = 10;
  localparam int Q = MHZ * QUS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic cfg_enable = 1'b0, user_mode = 1'b0, core_ready = 1'b0, link_active = 1'b0;
  logic route_to_cfg, clk_sel, hold_off;

  int vectors = 0, errors = 0, cycles = 0;
  string tag = "R9";

  // reference model state
  bit m_mode, m_sel, m_app;
  int m_phase, m_cnt; // 0 idle, 1 pre, 2 post

  always #4 clk = ~clk;

  cfgm_ctrl #(.DATA_W(DW), .CLK_MHZ(MHZ), .QUIET_US(QUS)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .cfg_enable(cfg_enable), .user_mode(user_mode), .core_ready(core_ready),
    .link_active(link_active), .route_to_cfg(route_to_cfg), .clk_sel(clk_sel),
    .hold_off(hold_off)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_sel = 0; m_app = 0; m_phase = 0; m_cnt = 0;
    end else begin
      bit want, n_mode, n_sel;
      want   = user_mode && core_ready && (m_sel != m_app);
      n_mode = cfg_enable ? (wr_en ? wr_data[0] : m_mode) : 1'b0;
      n_sel  = wr_en ? wr_data[1] : m_sel;
      case (m_phase)
        0: begin m_cnt = 0; if (want) m_phase = 1; end
        1: begin
          if (!want) begin m_phase = 0; m_cnt = 0; end
          else if (link_active) m_cnt = 0;
          else if (m_cnt == Q - 1) begin m_app = m_sel; m_phase = 2; m_cnt = 0; end
          else m_cnt++;
        end
        default: begin
          if (m_cnt == Q - 1) begin m_phase = 0; m_cnt = 0; end
          else m_cnt++;
        end
      endcase
      m_mode = n_mode; m_sel = n_sel;
    end
  end

  task automatic chk1(string what, logic act, bit exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  task automatic cyc();
    logic [DW-1:0] exp_rd;
    @(negedge clk);
    exp_rd = '0;
    exp_rd[0] = m_mode; exp_rd[1] = m_sel; exp_rd[2] = (m_phase != 0);
    vectors++;
    if (rd_data !== exp_rd) begin
      errors++;
      $display("FAIL %s rd_data: actual %h expected %h at cycle %0d", tag, rd_data, exp_rd, cycles);
    end
    chk1("route_to_cfg", route_to_cfg, m_mode);
    chk1("clk_sel", clk_sel, m_app);
    chk1("hold_off", hold_off, m_phase == 2);
  endtask

  task automatic wr(bit sel, bit mode);
    wr_en = 1'b1; wr_data = '0; wr_data[1] = sel; wr_data[0] = mode;
    cyc();
    wr_en = 1'b0; wr_data = '0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    tag = "R9"; cyc();

    tag = "R2"; wr(0, 1); cyc();
    tag = "R1"; cfg_enable = 1; wr(0, 1); cyc(); wr(0, 0); cyc(); wr(0, 1);
    tag = "R2"; cfg_enable = 0; wr(0, 1); cyc(); // write during enable fall
    cfg_enable = 1; wr(0, 1);
    tag = "R2"; cfg_enable = 0; cyc(); cyc();

    tag = "R4"; wr(1, 0); repeat (3 * Q) cyc();
    tag = "R5"; user_mode = 1; core_ready = 1; repeat (Q + 2) cyc();
    tag = "R7"; repeat (Q + 2) cyc();

    tag = "R6"; wr(0, 0);
    repeat (Q - 3) cyc();
    link_active = 1; cyc(); link_active = 0;
    repeat (Q - 2) cyc();
    link_active = 1; cyc(); link_active = 0;
    repeat (2 * Q + 4) cyc();

    tag = "R10"; wr(1, 0); repeat (Q / 2) cyc(); wr(0, 0); repeat (3) cyc();
    wr(1, 0); repeat (Q / 2) cyc(); core_ready = 0; repeat (Q + 2) cyc();
    core_ready = 1;

    tag = "R3";
    while (!(m_phase == 1 && m_cnt == Q - 1)) cyc();
    wr(0, 0); // write lands on window expiry
    repeat (3 * Q + 6) cyc();

    tag = "R8";
    for (int i = 0; i < 3000; i++) begin
      wr_en = ($urandom_range(0, 19) == 0);
      wr_data = '0; wr_data[1:0] = 2'($urandom_range(0, 3));
      cfg_enable = ($urandom_range(0, 7) != 0);
      user_mode = ($urandom_range(0, 15) != 0);
      core_ready = ($urandom_range(0, 15) != 0);
      link_active = ($urandom_range(0, 29) == 0);
      cyc();
    end
    wr_en = 0; link_active = 0;

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule